// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product. It uses one adder, reused over many clocks, in place of a wide array multiplier. A one-cycle request captures both operands. The block then walks through the multiplier one bit per clock. When the current low bit of the multiplier is set, the adder adds a widening copy of the multiplicand into an accumulating product. After each step the multiplicand moves one place left and the multiplier moves one place right.

The block always runs exactly 32 steps, whatever the operand values. It raises a one-cycle completion strobe after the last step, then returns to idle. The product stays on its output until the next request is accepted. A request that arrives while the block is working is dropped.

Top module: `shift_mul`

## Requirements
- R1: After reset, busy_o, done_o and product_o are all zero.
- R2: A start_i that is high at a clock edge while the block is idle is accepted. From the next cycle, busy_o is high and the product register is cleared. The operands present at that edge are captured.
- R3: The accepting edge is followed by exactly 32 step edges. done_o goes high after the 32nd step edge and stays high for exactly one cycle. busy_o stays high until done_o falls.
- R4: When done_o is high, product_o equals the unsigned 64-bit product of the captured operands. The accumulation never carries out of 64 bits.
- R5: On each step, the product grows by the multiplicand register only when bit 0 of the multiplier register is 1, and is otherwise unchanged. The multiplicand register then moves left by one and the multiplier register moves right by one, with zero filled in.
- R6: While busy_o is high, start_i and changes on the operand inputs have no effect on the result or on the completion timing.
- R7: From the end of a run until the next accepted start, product_o holds its value.
- R8: Multiplying 8 by 9 gives 72. A zero operand gives 0. All-ones times all-ones gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only while idle |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion strobe |
| product_o | output | 64 | 64-bit unsigned product |

## Verification
The bench drives inputs on falling edges. It counts rising edges from the one that accepts start_i. busy_o must be high one edge after acceptance. done_o must be low after step edges 1 to 31 and high, with the correct product, after edge 32. One edge later, done_o and busy_o must be low while product_o still holds the result. Intrusive starts and operand changes are injected mid-run, and the bench then confirms that the completion edge and the product are unchanged.

// File: rtl/shift_mul_pkg.sv
package shift_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/shift_mul_adder.sv
module shift_mul_adder #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p          = a_i[i] ^ b_i[i];
    assign sum_o[i]   = p ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_i[i]) | (p & carry[i]);
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/shift_mul_ctrl.sv
module shift_mul_ctrl
  import shift_mul_pkg::*;
#(
  parameter int unsigned STEPS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cnt_q) == LAST); // R3
  AST_RUN_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (step_o || done_o)); // R6
endmodule

// File: rtl/shift_mul_datapath.sv
module shift_mul_datapath #(
  parameter int unsigned OP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int unsigned PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] mcand_q, prod_q, sum;
  logic [OP_W-1:0]   mplier_q;
  logic              sum_cout;
  logic              add_en;

  shift_mul_adder #(.W(PROD_W)) u_adder (
    .a_i   (prod_q),
    .b_i   (mcand_q),
    .sum_o (sum),
    .cout_o(sum_cout)
  );

  assign add_en = step_i && mplier_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else if (load_i) begin
      mcand_q  <= {{OP_W{1'b0}}, mcand_i};
      mplier_q <= mplier_i;
      prod_q   <= '0;
    end else if (step_i) begin
      if (mplier_q[0]) prod_q <= sum;
      mcand_q  <= {mcand_q[PROD_W-2:0], 1'b0};
      mplier_q <= {1'b0, mplier_q[OP_W-1:1]};
    end
  end

  assign prod_o = prod_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_en |-> !sum_cout); // R4
  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (prod_q == '0) && (mplier_q == $past(mplier_i))); // R2
  AST_SKIP_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mplier_q[0]) |=> $stable(prod_q)); // R5
  AST_TOP_BIT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !mplier_q[OP_W-1] && !mcand_q[0]); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(prod_q)); // R7
endmodule

// File: rtl/shift_mul.sv
module shift_mul #(
  parameter int unsigned OP_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*OP_W-1:0] product_o
);
  logic load, step;

  shift_mul_ctrl #(.STEPS(OP_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  shift_mul_datapath #(.OP_W(OP_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mcand_i (mcand_i),
    .mplier_i(mplier_i),
    .prod_o  (product_o)
  );

  AST_PROD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o)); // R7
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R2
endmodule

// File: tb/shift_mul_tb_top.sv
`timescale 1ns/1ps
module shift_mul_tb_top;
  localparam int unsigned OP_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [OP_W-1:0]   mcand_i = '0;
  logic [OP_W-1:0]   mplier_i = '0;
  logic              busy_o, done_o;
  logic [2*OP_W-1:0] product_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  shift_mul #(.OP_W(OP_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  function automatic logic [2*OP_W-1:0] ref_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    logic [2*OP_W-1:0] ea, eb;
    ea = {{OP_W{1'b0}}, a};
    eb = {{OP_W{1'b0}}, b};
    return ea * eb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [2*OP_W-1:0] act,
                       input logic [2*OP_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // intrude: 0 none, 1 start + operand change mid-run
  task automatic run_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input int intrude);
    logic [2*OP_W-1:0] exp = ref_mul(a, b);
    bit early = 1'b0;
    @(negedge clk_i);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1 && product_o === '0, "R2 busy/clear after start",
          {busy_o, product_o[2*OP_W-2:0]}, {1'b1, {(2*OP_W-1){1'b0}}});
    for (int k = 1; k <= OP_W; k++) begin
      if (intrude != 0 && k == 5) begin
        start_i = 1'b1; mcand_i = ~a; mplier_i = b ^ 32'h5A5A_1234;
      end
      if (intrude != 0 && k == 7) start_i = 1'b0;
      @(negedge clk_i);
      if (k < OP_W && (done_o !== 1'b0 || busy_o !== 1'b1)) early = 1'b1;
    end
    start_i = 1'b0;
    check(!early, "R3 no early done", 64'(early), 64'd0);
    check(done_o === 1'b1, "R3 done after 32 steps", 64'(done_o), 64'd1);
    check(product_o === exp, intrude ? "R6 intrusion ignored" : "R4 product", product_o, exp);
    mcand_i = $urandom(); mplier_i = $urandom();
    @(negedge clk_i);
    check(done_o === 1'b0 && busy_o === 1'b0, "R3 one-cycle done, idle",
          64'({done_o, busy_o}), 64'd0);
    repeat (3) @(negedge clk_i);
    check(product_o === exp, "R7 product holds", product_o, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check(busy_o === 1'b0 && done_o === 1'b0 && product_o === '0, "R1 reset state",
          product_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_mul(32'd8, 32'd9, 0);                 // R8 example
    check(product_o === 64'd72, "R8 8*9", product_o, 64'd72);
    run_mul(32'd0, 32'hDEAD_BEEF, 0);         // R8 zero
    run_mul(32'h1234_5678, 32'd0, 0);
    run_mul('1, '1, 0);                       // R8 all ones
    check(product_o === 64'hFFFF_FFFE_0000_0001, "R8 max", product_o, 64'hFFFF_FFFE_0000_0001);
    run_mul(32'h8000_0000, 32'h8000_0001, 0); // R5 single/top bits
    run_mul(32'hFFFF_FFFF, 32'h0000_0001, 1); // R6 intrusion
    for (int i = 0; i < 20; i++) run_mul($urandom(), $urandom(), i % 3 == 0 ? 1 : 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule